// File: doc/BRIEF.md
# Cipher Command Queue Sequencer

This block sits between a host register port and two back-end movers: a block cipher engine and a DMA mover that copies data between external memory and an internal RAM. The host pushes 32-bit command words into a small inline queue. The sequencer pulls each word, reads the opcode in its top six bits, and turns it into work. Some commands need a second queue word that holds an address. The work is one of three kinds: a run of block requests to the cipher engine, a single transfer request to the DMA mover, or a table-load request that moves a key into a key slot.

Each back-end request is a level that stays high, with its fields held steady, until the matching acknowledge is seen. A testbench can therefore stand in for the engine and the mover with fixed-latency acknowledges. The host reads a status word that reports engine busy, DMA busy, queue empty and a transfer-done flag, together with three sticky error bits. Writing ones to the status address clears the done flag and the error bits. A small enable register gates the done and error sources onto an interrupt line.

Top module: `cmdq_sequencer`

## Requirements
- R1: After a synchronous active-high reset, the queue is empty, the decoder waits for an opcode word, and no request is raised. The status word reads 0x0000_0008 and the interrupt is low.
- R2: Queue words are executed in write order. A command write (address 0) to a full queue is dropped and sets the overflow bit 12 of the status word.
- R3: A command write that arrives while the engine is busy and the queue is not empty is rejected and sets the protocol-error bit 14. The queue is unchanged.
- R4: A word with an undefined opcode in bits [31:26] is discarded and sets the illegal-command bit 13. A table-load word whose key-id bit 20 is clear is treated the same way. Decoding then moves on to the next word.
- R5: Opcode 0x10 (DMA setup) consumes the next queue word as the source base address. Both words are consumed before the setup takes effect.
- R6: Opcode 0x0E starts the engine for N+1 blocks, where N is bits [BLK_W-1:0]. Block i is requested at base + 16*i, and each request is held until it is acknowledged.
- R7: Status bit 0 (busy) rises when a start word is taken. It stays high until every block has been acknowledged and an opcode 0x11 word has been consumed. A 0x11 word waits in the queue while blocks are still outstanding.
- R8: Opcode 0x22 takes its direction from bit 25 (1 = internal RAM to memory) and its word count from bits [24:12]. It then takes the external address from the next queue word. The DMA request is held until acknowledged, and status bit 23 is high while the request is pending.
- R9: Opcode 0x15 raises a table-load request with table selector bits [25:24], RAM selector bit 23 and key slot bits [19:17]. The request is held until acknowledged.
- R10: Status bit 1 (done) is set when a 0x11 word is consumed and when a DMA transfer is acknowledged. Writing ones to the status address (address 1) clears bit 1 and error bits [14:12]. A new event in the same cycle wins over the clear.
- R11: The interrupt equals (done AND enable bit 1) OR (any error AND enable bit 4). The enable register is written at address 2, and the value 0x33 enables both sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | 2 | Write target: 0 command queue, 1 status clear, 2 interrupt enable |
| wr_data | input | 32 | Host write data |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt line |
| blk_req | output | 1 | Block request to the cipher engine |
| blk_addr | output | 32 | Byte address of the requested block |
| blk_ack | input | 1 | Block acknowledge |
| dma_req | output | 1 | DMA transfer request |
| dma_dir | output | 1 | DMA direction, 1 = internal RAM to memory |
| dma_words | output | 13 | DMA word count |
| dma_addr | output | 32 | DMA external address |
| dma_ack | input | 1 | DMA acknowledge |
| tbl_req | output | 1 | Table-load request |
| tbl_sel | output | 2 | Table selector |
| tbl_ram | output | 1 | RAM selector |
| tbl_slot | output | 3 | Key slot number |
| tbl_ack | input | 1 | Table-load acknowledge |

## Verification
The bench builds the block with DEPTH=4 and BLK_W=4. The shallow queue can then be filled by four writes behind a stalled table load, which brings the overflow drop within reach in a few cycles. The four-bit count keeps block runs short while still testing the N+1 rule and the 16-byte address stride. The acknowledge inputs are held low on purpose at several points, so that request holding, a DMA-complete word waiting behind outstanding blocks, and the busy-and-not-empty write rejection all occur.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int CMD_W = 32;

  localparam logic [5:0] OP_SETUP  = 6'h10;
  localparam logic [5:0] OP_START  = 6'h0E;
  localparam logic [5:0] OP_FINISH = 6'h11;
  localparam logic [5:0] OP_TABLE  = 6'h15;
  localparam logic [5:0] OP_MEMDMA = 6'h22;

  localparam int DIR_BIT     = 25;
  localparam int WCNT_LSB    = 12;
  localparam int WCNT_W      = 13;
  localparam int TSEL_LSB    = 24;
  localparam int RAMSEL_BIT  = 23;
  localparam int KID_LSB     = 17;
  localparam int KID_VAL_BIT = 20;
  localparam int SLOT_W      = 3;
  localparam int ERR_W       = 3;

  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;
  localparam int SB_EMPTY = 3;
  localparam int SB_ERR_LSB = 12;
  localparam int SB_DMA = 23;
  localparam int IE_DONE = 1;
  localparam int IE_ERR = 4;

  typedef enum logic [1:0] {RA_CMD = 2'd0, RA_STAT = 2'd1, RA_IEN = 2'd2} reg_addr_e;
  typedef enum logic [1:0] {ST_OP, ST_ADDR, ST_XFER, ST_TBL} dec_state_e;

  function automatic logic [5:0] op_of(input logic [CMD_W-1:0] w);
    return w[31:26];
  endfunction

  function automatic logic [31:0] blk_addr_of(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 4);
  endfunction

  function automatic logic [31:0] pack_status(input logic busy, input logic done,
                                              input logic empty, input logic dma,
                                              input logic [ERR_W-1:0] err);
    logic [31:0] s;
    s = '0;
    s[SB_BUSY] = busy;
    s[SB_DONE] = done;
    s[SB_EMPTY] = empty;
    s[SB_ERR_LSB +: ERR_W] = err;
    s[SB_DMA] = dma;
    return s;
  endfunction
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop) rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;
endmodule

// File: rtl/cmdq_blk_engine.sv
module cmdq_blk_engine #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] start_cnt,
  input  logic             stop,
  input  logic [31:0]      base,
  input  logic             blk_ack,
  output logic             active,
  output logic             all_done,
  output logic             blk_req,
  output logic [31:0]      blk_addr
);
  import cmdq_pkg::*;
  localparam int TW = BLK_W + 1;

  logic [TW-1:0] total, issued;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      total  <= '0;
      issued <= '0;
    end else if (start) begin
      active <= 1'b1;
      total  <= {1'b0, start_cnt} + 1'b1;
      issued <= '0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (blk_req && blk_ack) begin
      issued <= issued + 1'b1;
    end
  end

  assign all_done = (issued == total);
  assign blk_req  = active && !all_done;
  assign blk_addr = blk_addr_of(base, {{(32-TW){1'b0}}, issued});
endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder #(
  parameter int BLK_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [31:0]                head,
  input  logic                       head_valid,
  input  logic                       eng_active,
  input  logic                       eng_done,
  input  logic                       dma_ack,
  input  logic                       tbl_ack,
  output logic                       pop,
  output logic                       start,
  output logic [BLK_W-1:0]           start_cnt,
  output logic                       stop,
  output logic                       ev_illegal,
  output logic                       ev_done,
  output logic [31:0]                src_addr,
  output logic                       dma_req,
  output logic                       dma_dir,
  output logic [cmdq_pkg::WCNT_W-1:0] dma_words,
  output logic [31:0]                dma_addr,
  output logic                       tbl_req,
  output logic [1:0]                 tbl_sel,
  output logic                       tbl_ram,
  output logic [cmdq_pkg::SLOT_W-1:0] tbl_slot
);
  import cmdq_pkg::*;

  dec_state_e st, st_n;
  logic pend_mem;
  logic take_setup, take_mem, take_tbl, take_addr;
  logic [5:0] op;

  assign op = op_of(head);
  assign start_cnt = head[BLK_W-1:0];

  always_comb begin
    st_n = st;
    pop = 1'b0;
    start = 1'b0;
    stop = 1'b0;
    ev_illegal = 1'b0;
    ev_done = 1'b0;
    take_setup = 1'b0;
    take_mem = 1'b0;
    take_tbl = 1'b0;
    take_addr = 1'b0;
    case (st)
      ST_OP: if (head_valid) begin
        case (op)
          OP_SETUP:  begin pop = 1'b1; take_setup = 1'b1; st_n = ST_ADDR; end
          OP_MEMDMA: begin pop = 1'b1; take_mem = 1'b1; st_n = ST_ADDR; end
          OP_START:  if (!eng_active) begin pop = 1'b1; start = 1'b1; end
          OP_FINISH: if (!eng_active || eng_done) begin
            pop = 1'b1; stop = 1'b1; ev_done = 1'b1;
          end
          OP_TABLE: begin
            pop = 1'b1;
            if (head[KID_VAL_BIT]) begin take_tbl = 1'b1; st_n = ST_TBL; end
            else ev_illegal = 1'b1;
          end
          default: begin pop = 1'b1; ev_illegal = 1'b1; end
        endcase
      end
      ST_ADDR: if (head_valid) begin
        pop = 1'b1;
        take_addr = 1'b1;
        st_n = pend_mem ? ST_XFER : ST_OP;
      end
      ST_XFER: if (dma_ack) begin ev_done = 1'b1; st_n = ST_OP; end
      ST_TBL:  if (tbl_ack) st_n = ST_OP;
      default: st_n = ST_OP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OP;
      pend_mem <= 1'b0;
      src_addr <= '0;
      dma_dir <= 1'b0;
      dma_words <= '0;
      dma_addr <= '0;
      tbl_sel <= '0;
      tbl_ram <= 1'b0;
      tbl_slot <= '0;
    end else begin
      st <= st_n;
      if (take_setup) pend_mem <= 1'b0;
      if (take_mem) begin
        pend_mem <= 1'b1;
        dma_dir <= head[DIR_BIT];
        dma_words <= head[WCNT_LSB +: WCNT_W];
      end
      if (take_addr) begin
        if (pend_mem) dma_addr <= head;
        else src_addr <= head;
      end
      if (take_tbl) begin
        tbl_sel <= head[TSEL_LSB +: 2];
        tbl_ram <= head[RAMSEL_BIT];
        tbl_slot <= head[KID_LSB +: SLOT_W];
      end
    end
  end

  assign dma_req = (st == ST_XFER);
  assign tbl_req = (st == ST_TBL);
endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer #(
  parameter int DEPTH = 8,
  parameter int BLK_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] status,
  output logic        irq,
  output logic        blk_req,
  output logic [31:0] blk_addr,
  input  logic        blk_ack,
  output logic        dma_req,
  output logic        dma_dir,
  output logic [12:0] dma_words,
  output logic [31:0] dma_addr,
  input  logic        dma_ack,
  output logic        tbl_req,
  output logic [1:0]  tbl_sel,
  output logic        tbl_ram,
  output logic [2:0]  tbl_slot,
  input  logic        tbl_ack
);
  import cmdq_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0] head;
  logic fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic [CW-1:0] fifo_cnt;
  logic eng_active, eng_done, eng_start, eng_stop;
  logic [BLK_W-1:0] start_cnt;
  logic [31:0] src_addr;
  logic ev_illegal, ev_done;
  logic cmd_wr, rej_busy, drop_full;
  logic [ERR_W-1:0] err, err_set;
  logic done_flag;
  logic [7:0] ien;

  assign cmd_wr    = wr_valid && (wr_addr == RA_CMD);
  assign rej_busy  = cmd_wr && eng_active && !fifo_empty;
  assign drop_full = cmd_wr && !rej_busy && fifo_full;
  assign fifo_push = cmd_wr && !rej_busy && !fifo_full;
  assign err_set   = {rej_busy, ev_illegal, drop_full};

  cmdq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .wdata(wr_data), .pop(fifo_pop),
    .rdata(head), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
  );

  cmdq_decoder #(.BLK_W(BLK_W)) u_dec (
    .clk(clk), .rst(rst), .head(head), .head_valid(!fifo_empty),
    .eng_active(eng_active), .eng_done(eng_done), .dma_ack(dma_ack), .tbl_ack(tbl_ack),
    .pop(fifo_pop), .start(eng_start), .start_cnt(start_cnt), .stop(eng_stop),
    .ev_illegal(ev_illegal), .ev_done(ev_done), .src_addr(src_addr),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_words(dma_words), .dma_addr(dma_addr),
    .tbl_req(tbl_req), .tbl_sel(tbl_sel), .tbl_ram(tbl_ram), .tbl_slot(tbl_slot)
  );

  cmdq_blk_engine #(.BLK_W(BLK_W)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .start_cnt(start_cnt), .stop(eng_stop),
    .base(src_addr), .blk_ack(blk_ack), .active(eng_active), .all_done(eng_done),
    .blk_req(blk_req), .blk_addr(blk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= '0;
      done_flag <= 1'b0;
      ien <= '0;
    end else begin
      if (wr_valid && wr_addr == RA_STAT) begin
        err <= (err & ~wr_data[SB_ERR_LSB +: ERR_W]) | err_set;
        done_flag <= (done_flag & ~wr_data[SB_DONE]) | ev_done;
      end else begin
        err <= err | err_set;
        done_flag <= done_flag | ev_done;
      end
      if (wr_valid && wr_addr == RA_IEN) ien <= wr_data[7:0];
    end
  end

  assign status = pack_status(eng_active, done_flag, fifo_empty, dma_req, err);
  assign irq = (done_flag && ien[IE_DONE]) || ((|err) && ien[IE_ERR]);
endmodule

// File: rtl/cmdq_sequencer_chk.sv
module cmdq_sequencer_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic [1:0]    wr_addr,
  input logic [31:0]   status,
  input logic          irq,
  input logic          blk_req,
  input logic          dma_req,
  input logic          dma_ack,
  input logic [31:0]   dma_addr,
  input logic          tbl_req,
  input logic          tbl_ack,
  input logic [2:0]    tbl_slot,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          eng_active,
  input logic          eng_done
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (status == 32'h8 && !irq)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) fifo_cnt <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 2'd0 && fifo_full && !eng_active) |=> status[12]); // R2
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 2'd0 && eng_active && !fifo_empty) |=> status[14]); // R3
  AST_BLK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) blk_req |-> status[0]); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eng_active && !eng_done) |=> eng_active); // R7
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_addr))); // R8
  AST_TBL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tbl_req && !tbl_ack) |=> (tbl_req && $stable(tbl_slot))); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status[1] || status[14:12] != 3'b000)); // R11
endmodule

bind cmdq_sequencer cmdq_sequencer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .status(status), .irq(irq),
  .blk_req(blk_req), .dma_req(dma_req), .dma_ack(dma_ack), .dma_addr(dma_addr),
  .tbl_req(tbl_req), .tbl_ack(tbl_ack), .tbl_slot(tbl_slot), .fifo_cnt(fifo_cnt),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .eng_active(eng_active), .eng_done(eng_done)
);

// File: tb/cmdq_sequencer_test.sv
module cmdq_sequencer_test;
  localparam int DEPTH = 4;
  localparam int BLK_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic blk_ack = 1'b1, dma_ack = 1'b1, tbl_ack = 1'b1;
  logic [31:0] status, blk_addr, dma_addr;
  logic irq, blk_req, dma_req, dma_dir, tbl_req, tbl_ram;
  logic [12:0] dma_words;
  logic [1:0] tbl_sel;
  logic [2:0] tbl_slot;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cmdq_sequencer #(.DEPTH(DEPTH), .BLK_W(BLK_W)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .status(status), .irq(irq), .blk_req(blk_req), .blk_addr(blk_addr), .blk_ack(blk_ack),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_words(dma_words), .dma_addr(dma_addr),
    .dma_ack(dma_ack), .tbl_req(tbl_req), .tbl_sel(tbl_sel), .tbl_ram(tbl_ram),
    .tbl_slot(tbl_slot), .tbl_ack(tbl_ack)
  );

  // behavioural reference model
  logic [31:0] mq[$];
  int mst = 0;            // 0 opcode, 1 address word, 2 dma pending, 3 table pending
  bit mpend = 0, meng = 0, mdir = 0, mtram = 0, mdone = 0;
  int mtot = 0, miss = 0;
  logic [31:0] msrc = 0, mdaddr = 0;
  logic [12:0] mwords = 0;
  logic [1:0] mtsel = 0;
  logic [2:0] mslot = 0, merr = 0;
  logic [7:0] mien = 0;
  logic [31:0] seen_blk[$];

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mst = 0; mpend = 0; meng = 0; mdone = 0; mtot = 0; miss = 0;
      msrc = 0; mdaddr = 0; mdir = 0; mwords = 0; mtsel = 0; mtram = 0; mslot = 0;
      merr = 0; mien = 0;
    end else begin
      int sz;
      bit old_eng, old_fin, hv;
      logic [31:0] h;
      sz = mq.size();
      old_eng = meng;
      old_fin = (miss == mtot);
      hv = (sz != 0);
      h = hv ? mq[0] : 32'd0;
      if (wr_valid && wr_addr == 2'd1) begin
        if (wr_data[1]) mdone = 0;
        merr = merr & ~wr_data[14:12];
      end
      if (old_eng && !old_fin && blk_ack) miss++;
      case (mst)
        0: if (hv) begin
          case (h[31:26])
            6'h10: begin void'(mq.pop_front()); mpend = 0; mst = 1; end
            6'h22: begin void'(mq.pop_front()); mpend = 1; mdir = h[25]; mwords = h[24:12]; mst = 1; end
            6'h0E: if (!old_eng) begin void'(mq.pop_front()); meng = 1; mtot = int'(h[BLK_W-1:0]) + 1; miss = 0; end
            6'h11: if (!old_eng || old_fin) begin void'(mq.pop_front()); meng = 0; mdone = 1; end
            6'h15: begin
              void'(mq.pop_front());
              if (h[20]) begin mtsel = h[25:24]; mtram = h[23]; mslot = h[19:17]; mst = 3; end
              else merr[1] = 1;
            end
            default: begin void'(mq.pop_front()); merr[1] = 1; end
          endcase
        end
        1: if (hv) begin
          void'(mq.pop_front());
          if (mpend) begin mdaddr = h; mst = 2; end else begin msrc = h; mst = 0; end
        end
        2: if (dma_ack) begin mdone = 1; mst = 0; end
        default: if (tbl_ack) mst = 0;
      endcase
      if (wr_valid && wr_addr == 2'd0) begin
        if (old_eng && sz != 0) merr[2] = 1;
        else if (sz == DEPTH) merr[0] = 1;
        else mq.push_back(wr_data);
      end
      if (wr_valid && wr_addr == 2'd2) mien = wr_data[7:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [31:0] es;
      bit ebr, eirq;
      es = 32'd0;
      es[0] = meng; es[1] = mdone; es[3] = (mq.size() == 0);
      es[14:12] = merr; es[23] = (mst == 2);
      ebr = meng && (miss != mtot);
      eirq = (mdone && mien[1]) || ((merr != 0) && mien[4]);
      chk(status == es, "R10 status", status, es);
      chk(irq == eirq, "R11 irq", {31'd0, irq}, {31'd0, eirq});
      chk(blk_req == ebr, "R6 blk_req", {31'd0, blk_req}, {31'd0, ebr});
      if (ebr) chk(blk_addr == msrc + 32'(miss * 16), "R6 blk_addr", blk_addr, msrc + 32'(miss * 16));
      chk(dma_req == (mst == 2), "R8 dma_req", {31'd0, dma_req}, {31'd0, mst == 2});
      if (mst == 2) chk({dma_dir, dma_words} == {mdir, mwords} && dma_addr == mdaddr,
                        "R8 dma fields", dma_addr, mdaddr);
      chk(tbl_req == (mst == 3), "R9 tbl_req", {31'd0, tbl_req}, {31'd0, mst == 3});
      if (mst == 3) chk({tbl_sel, tbl_ram, tbl_slot} == {mtsel, mtram, mslot},
                        "R9 tbl fields", {26'd0, tbl_sel, tbl_ram, tbl_slot}, {26'd0, mtsel, mtram, mslot});
      if (blk_req && blk_ack) seen_blk.push_back(blk_addr);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(4);
    // R1 reset state
    chk(status == 32'h8, "R1 reset status", status, 32'h8);
    chk(!irq && !blk_req && !dma_req && !tbl_req, "R1 no request", {28'd0, irq, blk_req, dma_req, tbl_req}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R5, R6, R7: setup, three blocks, completion
    wr(2'd2, 32'h33);
    wr(2'd0, 32'h4000_0000);
    wr(2'd0, 32'h0000_1000);
    wr(2'd0, 32'h3800_0002);
    wr(2'd0, 32'h4400_0000);
    idle(8);
    chk(seen_blk.size() == 3, "R6 block count", seen_blk.size(), 3);
    if (seen_blk.size() == 3) begin
      chk(seen_blk[0] == 32'h1000, "R5 first block at base", seen_blk[0], 32'h1000);
      chk(seen_blk[2] == 32'h1020, "R6 stride 16", seen_blk[2], 32'h1020);
    end
    chk(status[1] && !status[0], "R7 idle and done", status, 32'h0000_000A);
    chk(irq == 1'b1, "R11 done irq", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h0);
    chk(irq == 1'b0, "R11 irq gated", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h33);
    wr(2'd1, 32'h2);
    chk(status == 32'h8, "R10 done cleared", status, 32'h8);

    // R3, R7: busy with outstanding blocks
    blk_ack = 1'b0;
    wr(2'd0, 32'h3800_0001);
    idle(2);
    wr(2'd0, 32'h4400_0000);
    wr(2'd0, 32'h4400_0000);
    idle(2);
    chk(status[14] == 1'b1, "R3 reject flagged", status, 32'h0000_4001);
    chk(status[0] && !status[3], "R7 finish waits", status, 32'h0000_4001);
    chk(irq == 1'b1, "R11 error irq", {31'd0, irq}, 32'd1);
    blk_ack = 1'b1;
    idle(6);
    chk(!status[0] && status[1] && status[3], "R7 busy released", status, 32'h0000_400A);
    wr(2'd1, 32'h0000_7002);
    chk(status == 32'h8, "R10 errors cleared", status, 32'h8);

    // R2, R4, R8, R9: stalled table load, full queue, illegal words, memory DMA
    tbl_ack = 1'b0;
    dma_ack = 1'b0;
    wr(2'd0, 32'h579A_0000);
    idle(1);
    chk(tbl_req && tbl_slot == 3'd5 && tbl_sel == 2'd3 && tbl_ram, "R9 table fields",
        {26'd0, tbl_sel, tbl_ram, tbl_slot}, 32'h3D);
    wr(2'd0, 32'hFC00_0000);
    wr(2'd0, 32'h5780_0000);
    wr(2'd0, 32'h8A01_0000);
    wr(2'd0, 32'h2000_0040);
    wr(2'd0, 32'h8800_0000);
    chk(status[12] == 1'b1, "R2 overflow flagged", status, 32'h0000_1000);
    tbl_ack = 1'b1;
    idle(6);
    chk(status[13] == 1'b1, "R4 illegal flagged", status, 32'h0000_3000);
    chk(dma_req && dma_dir && dma_words == 13'd16 && dma_addr == 32'h2000_0040, "R8 dma fields",
        dma_addr, 32'h2000_0040);
    chk(status[23] == 1'b1, "R8 dma busy", status, 32'h0080_0000);
    dma_ack = 1'b1;
    idle(4);
    chk(!dma_req && status[3] && status[1], "R2 dropped word not run", status, 32'h0000_300A);
    wr(2'd1, 32'h0000_7002);
    chk(status == 32'h8 && !irq, "R10 final clear", status, 32'h8);

    // R1 reset in mid-run
    blk_ack = 1'b0;
    wr(2'd0, 32'h3800_0003);
    idle(2);
    @(negedge clk); rst = 1'b1;
    idle(2);
    chk(status == 32'h8 && !blk_req, "R1 reset mid-run", status, 32'h8);
    rst = 1'b0;
    idle(2);
    finish_run();
  end
endmodule